// File: doc/BRIEF.md
# Host Parallel Port Byte Assembler (4/8-bit)

This block sits between a host's parallel bus and the command logic of a character display controller. The host drives eight data lines, a register-select line, a read/write line and an enable strobe. The block samples the lines while the strobe is high and acts when the strobe falls. It hands the controller core one complete byte per write, tagged as instruction or display data and marked by a one-cycle valid pulse.

The port has two widths. In wide mode every strobe carries a whole byte. In narrow mode only the upper four lines are used, and two strobes form one byte, high nibble first. Reads are split the same way: the core's read-back byte (busy flag plus address counter, or data) goes out whole, or as two nibbles. The block watches the instruction stream for the width-selecting instruction and switches the width itself.

After reset the port is wide. A host wired for four lines leaves the lower lines to their pull-ups, so its first width instruction reaches the core with the low four bits set to ones. It takes effect in one strobe. A second width instruction, sent as two nibbles, then carries the intended low bits.

Top module: `pbus_host_port`

## Requirements
- R1: After reset `wide_o` is 1, `byte_vld_o` and `rd_ack_o` are 0, `bus_d_oe` is 0 while the strobe is low, and the next strobe is the first nibble of a byte.
- R2: In wide mode each falling strobe with `rd_i`=0 gives one `byte_vld_o` pulse. `byte_o` carries all eight lines. `byte_is_data_o` equals `sel_i` (1 = display data, 0 = instruction).
- R3: In narrow mode a write byte takes two strobes. Lines 7..4 of the first strobe form `byte_o[7:4]` and lines 7..4 of the second form `byte_o[3:0]`. Lines 3..0 are ignored. There is exactly one valid pulse, after the second strobe.
- R4: An instruction byte (`sel_i`=0) whose bits 7..5 are 001 sets the width from its bit 4 (1 = wide, 0 = narrow) for the following strobes. The byte is still emitted. `wide_o` changes only in the cycle that byte is emitted.
- R5: In wide mode, with lines 3..0 pulled high, a single strobe carrying 0010 on lines 7..4 emits 0x2F and switches to narrow. A following two-nibble width instruction emits its exact value.
- R6: Every width change leaves the nibble phase at the first nibble, so the next strobe starts a new byte in the new width.
- R7: In wide mode a strobe with `rd_i`=1 drives `rdback_i` onto `bus_d_o` while the strobe is high, gives one `rd_ack_o` pulse after it falls, and gives no `byte_vld_o`.
- R8: In narrow mode a read takes two strobes. The first drives `rdback_i[7:4]` and the second drives `rdback_i[3:0]` on `bus_d_o[7:4]`, with `bus_d_o[3:0]`=0. One `rd_ack_o` pulse follows the second strobe.
- R9: `bus_d_oe` is 1 only while the strobe is high with `rd_i`=1.
- R10: `byte_vld_o` and `rd_ack_o` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_d_i | input | 8 | Host data lines as seen at the pads |
| bus_d_o | output | 8 | Read data driven toward the host |
| bus_d_oe | output | 1 | Output enable for `bus_d_o` |
| sel_i | input | 1 | Register select: 1 display data, 0 instruction |
| rd_i | input | 1 | 1 read, 0 write |
| strobe_i | input | 1 | Asynchronous enable strobe from the host |
| rdback_i | input | 8 | Byte the core offers for reads |
| byte_o | output | 8 | Assembled byte |
| byte_is_data_o | output | 1 | Kind of `byte_o`: 1 data, 0 instruction |
| byte_vld_o | output | 1 | One-cycle pulse: `byte_o` is new |
| rd_ack_o | output | 1 | One-cycle pulse: a full read byte was taken |
| wide_o | output | 1 | Current width: 1 eight lines, 0 four lines |

## Verification
Two events land on the same clock edge: a width instruction completes as an emitted byte, and the width it selects (with a cleared nibble phase) takes effect. The bench provokes this by sending width instructions in both directions. That includes the single-strobe one with pulled-up low lines and a two-nibble one that ends in wide mode. It then follows each with a strobe that only decodes correctly under the new width and phase. The scoreboard judges this by the byte that results and by `wide_o`. A checker also requires any change of width to coincide with a valid pulse and a phase of zero.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int BUS_W = 8;
  localparam int NIB_W = BUS_W / 2;

  // Pin snapshot taken while the strobe is high.
  typedef struct packed {
    logic             sel;
    logic             rd;
    logic [BUS_W-1:0] d;
  } pin_snap_t;

  // Width instruction: bits 7..5 = 001, bit 4 chooses the width.
  localparam logic [2:0] WIDTH_OP = 3'b001;
  localparam int         WIDTH_BIT = 4;

  function automatic logic is_width_op(input logic [BUS_W-1:0] b);
    return b[BUS_W-1 -: 3] == WIDTH_OP;
  endfunction
endpackage

// File: rtl/pbus_strobe_sync.sv
module pbus_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= strobe_i;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else        chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign fall_o  = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/pbus_nibble_seq.sv
module pbus_nibble_seq
  import pbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_i,
  input  pin_snap_t        snap_i,
  output logic [BUS_W-1:0] byte_o,
  output logic             kind_o,
  output logic             vld_o,
  output logic             ack_o,
  output logic             wide_o,
  output logic             phase_o
);
  logic [BUS_W-1:0] byte_q, byte_n;
  logic             kind_q, kind_n;
  logic             vld_q, vld_n;
  logic             ack_q, ack_n;
  logic             wide_q, wide_n;
  logic             phase_q, phase_n;
  logic [NIB_W-1:0] hold_q, hold_n;
  logic [BUS_W-1:0] assembled;
  logic             done;

  always_comb begin
    byte_n    = byte_q;
    kind_n    = kind_q;
    vld_n     = 1'b0;
    ack_n     = 1'b0;
    wide_n    = wide_q;
    phase_n   = phase_q;
    hold_n    = hold_q;
    assembled = byte_q;
    done      = 1'b0;
    if (fall_i) begin
      if (snap_i.rd) begin
        if (wide_q) begin
          ack_n = 1'b1;
        end else begin
          ack_n   = phase_q;
          phase_n = ~phase_q;
        end
      end else if (wide_q) begin
        assembled = snap_i.d;
        done      = 1'b1;
      end else if (!phase_q) begin
        hold_n  = snap_i.d[BUS_W-1 -: NIB_W];
        phase_n = 1'b1;
      end else begin
        assembled = {hold_q, snap_i.d[BUS_W-1 -: NIB_W]};
        done      = 1'b1;
        phase_n   = 1'b0;
      end
      if (done) begin
        byte_n = assembled;
        kind_n = snap_i.sel;
        vld_n  = 1'b1;
        if (!snap_i.sel && is_width_op(assembled)) begin
          wide_n  = assembled[WIDTH_BIT];
          phase_n = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q  <= '0;
      kind_q  <= 1'b0;
      vld_q   <= 1'b0;
      ack_q   <= 1'b0;
      wide_q  <= 1'b1;
      phase_q <= 1'b0;
      hold_q  <= '0;
    end else begin
      byte_q  <= byte_n;
      kind_q  <= kind_n;
      vld_q   <= vld_n;
      ack_q   <= ack_n;
      wide_q  <= wide_n;
      phase_q <= phase_n;
      hold_q  <= hold_n;
    end
  end

  assign byte_o  = byte_q;
  assign kind_o  = kind_q;
  assign vld_o   = vld_q;
  assign ack_o   = ack_q;
  assign wide_o  = wide_q;
  assign phase_o = phase_q;
endmodule

// File: rtl/pbus_read_mux.sv
module pbus_read_mux
  import pbus_pkg::*;
(
  input  logic [BUS_W-1:0] rdback_i,
  input  logic             wide_i,
  input  logic             phase_i,
  input  logic             strobe_i,
  input  logic             rd_i,
  output logic [BUS_W-1:0] d_o,
  output logic             oe_o
);
  logic [NIB_W-1:0] nib;

  always_comb begin
    nib = phase_i ? rdback_i[NIB_W-1:0] : rdback_i[BUS_W-1 -: NIB_W];
    if (wide_i) d_o = rdback_i;
    else        d_o = {nib, {NIB_W{1'b0}}};
  end

  assign oe_o = strobe_i & rd_i;
endmodule

// File: rtl/pbus_host_port.sv
module pbus_host_port
  import pbus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] bus_d_i,
  output logic [BUS_W-1:0] bus_d_o,
  output logic             bus_d_oe,
  input  logic             sel_i,
  input  logic             rd_i,
  input  logic             strobe_i,
  input  logic [BUS_W-1:0] rdback_i,
  output logic [BUS_W-1:0] byte_o,
  output logic             byte_is_data_o,
  output logic             byte_vld_o,
  output logic             rd_ack_o,
  output logic             wide_o
);
  logic      rst_meta_q, rst_int_n;
  logic      strobe_lvl, strobe_fall;
  pin_snap_t snap_q, snap_n;
  logic      nib_phase;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  pbus_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .strobe_i (strobe_i),
    .level_o  (strobe_lvl),
    .fall_o   (strobe_fall)
  );

  // Pins are sampled every cycle the synchronised strobe is high.
  always_comb begin
    snap_n = snap_q;
    if (strobe_lvl) begin
      snap_n.sel = sel_i;
      snap_n.rd  = rd_i;
      snap_n.d   = bus_d_i;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) snap_q <= '0;
    else            snap_q <= snap_n;
  end

  pbus_nibble_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .fall_i  (strobe_fall),
    .snap_i  (snap_q),
    .byte_o  (byte_o),
    .kind_o  (byte_is_data_o),
    .vld_o   (byte_vld_o),
    .ack_o   (rd_ack_o),
    .wide_o  (wide_o),
    .phase_o (nib_phase)
  );

  pbus_read_mux u_rmux (
    .rdback_i (rdback_i),
    .wide_i   (wide_o),
    .phase_i  (nib_phase),
    .strobe_i (strobe_i),
    .rd_i     (rd_i),
    .d_o      (bus_d_o),
    .oe_o     (bus_d_oe)
  );
endmodule

// File: rtl/pbus_host_port_chk.sv
module pbus_host_port_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_i,
  input logic strobe_i,
  input logic bus_d_oe,
  input logic byte_vld_o,
  input logic rd_ack_o,
  input logic wide_o,
  input logic phase
);
  // R9
  oe_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_i || !strobe_i) |-> !bus_d_oe);

  // R10
  vld_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_o |=> !byte_vld_o);

  // R10
  vld_ack_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_vld_o && rd_ack_o));

  // R4
  width_moves_with_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wide_o) |-> byte_vld_o);

  // R6
  width_change_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wide_o) |-> !phase);

  // R8
  ack_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack_o |=> !rd_ack_o);
endmodule

bind pbus_host_port pbus_host_port_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .rd_i       (rd_i),
  .strobe_i   (strobe_i),
  .bus_d_oe   (bus_d_oe),
  .byte_vld_o (byte_vld_o),
  .rd_ack_o   (rd_ack_o),
  .wide_o     (wide_o),
  .phase      (nib_phase)
);

// File: tb/pbus_host_port_bench.sv
module pbus_host_port_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_d_i, bus_d_o, rdback_i, byte_o;
  logic       bus_d_oe, sel_i, rd_i, strobe_i;
  logic       byte_is_data_o, byte_vld_o, rd_ack_o, wide_o;

  int checks = 0;
  int errors = 0;

  logic [8:0] exp_q[$];
  int         ack_q[$];

  logic       m_wide;
  logic       m_phase;
  logic [3:0] m_hold;
  logic       prev_vld;

  always #4 clk = ~clk;

  pbus_host_port u_pbus_host_port (
    .clk(clk), .rst_n(rst_n), .bus_d_i(bus_d_i), .bus_d_o(bus_d_o),
    .bus_d_oe(bus_d_oe), .sel_i(sel_i), .rd_i(rd_i), .strobe_i(strobe_i),
    .rdback_i(rdback_i), .byte_o(byte_o), .byte_is_data_o(byte_is_data_o),
    .byte_vld_o(byte_vld_o), .rd_ack_o(rd_ack_o), .wide_o(wide_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pop scoreboard entries as results appear.
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (byte_vld_o) begin
        check(!prev_vld, "R10 pulse width", 1, 0);
        if (exp_q.size() == 0) check(1'b0, "R2 unexpected byte", {byte_is_data_o, byte_o}, 0);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          check({byte_is_data_o, byte_o} == e, "R2/R3 byte", {byte_is_data_o, byte_o}, e);
        end
      end
      if (rd_ack_o) begin
        if (ack_q.size() == 0) check(1'b0, "R7/R8 unexpected ack", 1, 0);
        else void'(ack_q.pop_front());
        check(!byte_vld_o, "R7 no byte on read", byte_vld_o, 0);
      end
      prev_vld <= byte_vld_o;
    end
  end

  // One strobe; the model predicts the port's reaction.
  task automatic xfer(input logic sel, input logic rd, input logic [7:0] pins,
                      input logic [7:0] rb);
    logic [7:0] full;
    logic       done;
    @(negedge clk);
    sel_i = sel; rd_i = rd; bus_d_i = pins; rdback_i = rb;
    @(negedge clk);
    strobe_i = 1'b1;
    repeat (3) @(negedge clk);
    if (rd) begin
      logic [7:0] ed;
      ed = m_wide ? rb : {(m_phase ? rb[3:0] : rb[7:4]), 4'h0};
      check(bus_d_oe === 1'b1, m_wide ? "R7 oe" : "R8 oe", bus_d_oe, 1);
      check(bus_d_o === ed, m_wide ? "R7 read data" : "R8 read nibble", bus_d_o, ed);
    end else begin
      check(bus_d_oe === 1'b0, "R9 oe on write", bus_d_oe, 0);
    end
    done = 1'b0;
    full = 8'h00;
    if (rd) begin
      if (m_wide || m_phase) ack_q.push_back(1);
      if (!m_wide) m_phase = ~m_phase;
    end else if (m_wide) begin
      full = pins; done = 1'b1;
    end else if (!m_phase) begin
      m_hold = pins[7:4]; m_phase = 1'b1;
    end else begin
      full = {m_hold, pins[7:4]}; done = 1'b1; m_phase = 1'b0;
    end
    if (done) begin
      exp_q.push_back({sel, full});
      if (!sel && full[7:5] == 3'b001) begin
        m_wide = full[4]; m_phase = 1'b0;
      end
    end
    strobe_i = 1'b0;
    @(negedge clk);
    check(bus_d_oe === 1'b0, "R9 oe after strobe", bus_d_oe, 0);
    repeat (6) @(negedge clk);
  endtask

  // Host with only four lines wired: low lines float high.
  task automatic nib_write(input logic sel, input logic [7:0] b);
    xfer(sel, 1'b0, {b[7:4], 4'hF}, 8'h00);
    xfer(sel, 1'b0, {b[3:0], 4'hF}, 8'h00);
  endtask

  initial begin
    #1_000_000;
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; strobe_i = 1'b0; sel_i = 1'b0; rd_i = 1'b0;
    bus_d_i = 8'h00; rdback_i = 8'h00; prev_vld = 1'b0;
    m_wide = 1'b1; m_phase = 1'b0; m_hold = 4'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    check(wide_o === 1'b1, "R1 wide after reset", wide_o, 1);
    check(byte_vld_o === 1'b0 && rd_ack_o === 1'b0, "R1 pulses idle", byte_vld_o, 0);
    check(bus_d_oe === 1'b0, "R1 oe idle", bus_d_oe, 0);

    // R2 wide writes of both kinds
    xfer(1'b1, 1'b0, 8'hA5, 8'h00);
    xfer(1'b0, 1'b0, 8'h01, 8'h00);
    xfer(1'b1, 1'b0, 8'h5A, 8'h00);
    // R7 wide read
    xfer(1'b0, 1'b1, 8'h00, 8'hC3);

    // R5 single strobe from a four-line host: 0x2F, width goes narrow
    xfer(1'b0, 1'b0, 8'h2F, 8'h00);
    repeat (2) @(negedge clk);
    check(wide_o === 1'b0, "R4 narrow after width op", wide_o, 0);
    // R5 second width instruction as two nibbles
    nib_write(1'b0, 8'h28);
    check(wide_o === 1'b0, "R5 still narrow", wide_o, 0);
    // R3 narrow data, low lines ignored
    nib_write(1'b1, 8'h7E);
    nib_write(1'b1, 8'h81);
    xfer(1'b1, 1'b0, 8'h3C, 8'h00);
    xfer(1'b1, 1'b0, 8'hD0, 8'h00);
    // R8 narrow read as two nibbles
    xfer(1'b0, 1'b1, 8'h00, 8'h9B);
    xfer(1'b0, 1'b1, 8'h00, 8'h9B);

    // R6 back to wide with a two-nibble width op, then a single-strobe byte
    nib_write(1'b0, 8'h30);
    check(wide_o === 1'b1, "R6 wide again", wide_o, 1);
    xfer(1'b1, 1'b0, 8'h44, 8'h00);
    // R6 wide to narrow in one strobe, next pair starts a new byte
    xfer(1'b0, 1'b0, 8'h20, 8'h00);
    nib_write(1'b1, 8'hB6);
    // R4 an instruction that is not a width op leaves the width alone
    nib_write(1'b0, 8'h0C);
    check(wide_o === 1'b0, "R4 other op keeps width", wide_o, 0);
    // R4 data byte with width-op bits does not switch width
    nib_write(1'b1, 8'h30);
    check(wide_o === 1'b0, "R4 data ignored for width", wide_o, 0);

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R2/R3 all bytes seen", exp_q.size(), 0);
    check(ack_q.size() == 0, "R7/R8 all acks seen", ack_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule